// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block sits right after the receive byte stream of an Ethernet MAC and decides, for each frame, whether that frame is kept. It collects the first six bytes of the frame (the destination address) and works out how the address is addressed: to this station, to a group, or to everyone. It then combines that result with four enable flags and emits one accept or reject verdict. The first byte of a frame arrives with a start strobe. Each byte is qualified by a valid strobe, and the frame's last byte carries an end strobe.

Group addresses can be screened through a 64-entry hash table. The table index comes from a CRC-32 computed over the six destination bytes while they stream in, so no extra cycles are spent after the last address byte. The enable flags are held in a small register with a simple write port and a read-back port.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset the four filter flags read as zero. A write stores the low four bits of the write data, and they appear at `cfgRdData[3:0]`: bit 3 promiscuous, bit 2 any-group, bit 1 hashed-group, bit 0 all-ones.
- R2: `cfgRdData[7:4]` always reads zero, and ones written to those bit positions are discarded.
- R3: With the promiscuous flag set, every frame that delivers six address bytes is accepted, whatever its destination.
- R4: An address whose first byte has LSB 0 is accepted when all 48 bits equal `stationAddr`. The first received byte is compared with `stationAddr[47:40]` and the sixth with `stationAddr[7:0]`.
- R5: An address whose first byte has LSB 1, and which is not all ones, is a group address. With the any-group flag set it is accepted. The all-ones flag alone does not accept it.
- R6: With the hashed-group flag set, a group address is accepted when `hashTable[idx]` is 1. Here `idx` is bits [31:26] of a reflected CRC-32 register (polynomial 0xEDB88320, preset to all ones, each byte fed LSB first, no final inversion) after the six address bytes in arrival order.
- R7: The all-ones address (FF:FF:FF:FF:FF:FF) is accepted only when the all-ones flag is set. The two group flags never accept it.
- R8: A frame that no enabled rule accepts is rejected.
- R9: `decisionValid` is high for exactly one cycle, in the cycle after the clock edge that samples the sixth valid address byte. Later bytes and the end strobe of that frame produce no further verdict.
- R10: If the end strobe arrives before the sixth address byte, `decisionValid` pulses one cycle later with `accept` low, even in promiscuous mode.
- R11: A start strobe discards any partly collected address and begins a new one with its own byte as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Marks the first byte of a frame, qualified by byteValid |
| byteValid | input | 1 | byteData carries a received byte |
| byteData | input | 8 | Received byte |
| frameEnd | input | 1 | Marks the last byte of a frame |
| stationAddr | input | 48 | This station's address, first transmitted byte in [47:40] |
| hashTable | input | 64 | Group hash table, one bit per index |
| cfgWrEn | input | 1 | Write strobe for the flag register |
| cfgWrData | input | 8 | Flag register write data |
| cfgRdData | output | 8 | Flag register read-back |
| decisionValid | output | 1 | One-cycle verdict strobe |
| accept | output | 1 | Verdict, valid while decisionValid is high |

## Verification
A byte counter that slips by one shifts every address byte. That breaks the station compare and the CRC, and it moves the verdict strobe, so the fault shows up on the very next frame as a wrong verdict or a strobe in the wrong cycle. A stale active flag after a verdict shows up as a second pulse while the payload bytes that follow are still arriving. A wrong CRC preset or bit order only becomes visible on a hashed-group frame: a table with just the expected bit set then rejects where it should accept. For that reason, both a single-bit table and its complement are used.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = 8 * ADDR_BYTES;
  localparam int CNT_W      = $clog2(ADDR_BYTES + 1);
  localparam int CFG_W      = 4;
  localparam int CFG_BCAST  = 0;
  localparam int CFG_HASH   = 1;
  localparam int CFG_MCAST  = 2;
  localparam int CFG_PROM   = 3;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  typedef struct packed {
    logic load;      // capture byteData into address/CRC
    logic first;     // restart CRC from preset
    logic last;      // sixth address byte present this cycle
    logic shortEnd;  // frame ended before address completed
  } ctlStb_t;
endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sof,
  input  logic    byteValid,
  input  logic    frameEnd,
  output ctlStb_t stb
);
  logic             active;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] idx;
  logic             take;

  always_comb begin
    take         = byteValid & (sof | active);
    idx          = sof ? '0 : count;
    stb.load     = take;
    stb.first    = take & sof;
    stb.last     = take & (idx == CNT_W'(ADDR_BYTES - 1));
    stb.shortEnd = frameEnd & (active | take) & ~stb.last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      count  <= '0;
    end else if (stb.last || stb.shortEnd) begin
      active <= 1'b0;
      count  <= '0;
    end else if (take) begin
      active <= 1'b1;
      count  <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/rxf_datapath.sv
module rxf_datapath
  import rxf_pkg::*;
#(
  parameter int HASH_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        byteData,
  input  ctlStb_t           stb,
  input  logic [ADDR_W-1:0] stationAddr,
  input  logic [HASH_W-1:0] hashTable,
  input  logic [CFG_W-1:0]  cfgFlags,
  output logic              decisionValid,
  output logic              accept
);
  localparam int IDX_W  = $clog2(HASH_W);
  localparam int HOLD_W = ADDR_W - 8;

  function automatic logic [31:0] crcByte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int k = 0; k < 8; k++) begin
      if (r[0] ^ d[k]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

  logic [HOLD_W-1:0] addrReg;
  logic [31:0]       crcReg, crcIn, crcNext;
  logic [ADDR_W-1:0] fullAddr;
  logic [IDX_W-1:0]  hashIdx;
  logic              hashHit, isBcast, groupBit, isGroup, stationHit, acceptNext;

  always_comb begin
    crcIn      = stb.first ? '1 : crcReg;
    crcNext    = crcByte(crcIn, byteData);
    fullAddr   = {addrReg, byteData};
    hashIdx    = crcNext[31 -: IDX_W];
    hashHit    = hashTable[hashIdx];
    isBcast    = &fullAddr;
    groupBit   = fullAddr[ADDR_W-8];
    isGroup    = groupBit & ~isBcast;
    stationHit = ~groupBit & (fullAddr == stationAddr);
    acceptNext = cfgFlags[CFG_PROM]
               | (isBcast & cfgFlags[CFG_BCAST])
               | (isGroup & (cfgFlags[CFG_MCAST] | (cfgFlags[CFG_HASH] & hashHit)))
               | stationHit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addrReg       <= '0;
      crcReg        <= '1;
      decisionValid <= 1'b0;
      accept        <= 1'b0;
    end else begin
      if (stb.load) begin
        addrReg <= {addrReg[HOLD_W-9:0], byteData};
        crcReg  <= crcNext;
      end
      decisionValid <= stb.last | stb.shortEnd;
      accept        <= stb.last & acceptNext;
    end
  end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rxf_pkg::*;
#(
  parameter int HASH_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              frameEnd,
  input  logic [ADDR_W-1:0] stationAddr,
  input  logic [HASH_W-1:0] hashTable,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  output logic              decisionValid,
  output logic              accept
);
  localparam logic [7:0] CFG_MASK = 8'((1 << CFG_W) - 1);

  logic [7:0] cfgReg;
  ctlStb_t    ctlStb;

  always_ff @(posedge clk) begin
    if (!rst_n)       cfgReg <= '0;
    else if (cfgWrEn) cfgReg <= cfgWrData & CFG_MASK;
  end

  assign cfgRdData = cfgReg;

  rxf_ctrl uCtrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sof       (sof),
    .byteValid (byteValid),
    .frameEnd  (frameEnd),
    .stb       (ctlStb)
  );

  rxf_datapath #(.HASH_W(HASH_W)) uData (
    .clk           (clk),
    .rst_n         (rst_n),
    .byteData      (byteData),
    .stb           (ctlStb),
    .stationAddr   (stationAddr),
    .hashTable     (hashTable),
    .cfgFlags      (cfgReg[CFG_W-1:0]),
    .decisionValid (decisionValid),
    .accept        (accept)
  );
endmodule

// File: rtl/rx_dest_filter_chk.sv
module rx_dest_filter_chk
  import rxf_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cfgRdData,
  input logic       decisionValid,
  input logic       accept,
  input ctlStb_t    stb
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfgRdData[7:4] == 4'h0); // R2

  AST_PROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.last && cfgRdData[CFG_PROM]) |=> (decisionValid && accept)); // R3

  AST_SHORT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    stb.shortEnd |=> (decisionValid && !accept)); // R10

  AST_VERDICT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    decisionValid |-> $past(stb.last || stb.shortEnd)); // R9

  AST_ACCEPT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> decisionValid); // R9
endmodule

bind rx_dest_filter rx_dest_filter_chk uChk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfgRdData     (cfgRdData),
  .decisionValid (decisionValid),
  .accept        (accept),
  .stb           (ctlStb)
);

// File: tb/rx_dest_filter_bench.sv
module rx_dest_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof = 1'b0, byteValid = 1'b0, frameEnd = 1'b0;
  logic [7:0]  byteData = 8'h00;
  logic [47:0] stationAddr = 48'h02_11_22_33_44_55;
  logic [63:0] hashTable = 64'h0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgWrData = 8'h00;
  logic [7:0]  cfgRdData;
  logic        decisionValid, accept;
  int          checks = 0, errors = 0;

  always #10 clk = ~clk; // 50 MHz

  rx_dest_filter u_rx_dest_filter (
    .clk(clk), .rst_n(rst_n), .sof(sof), .byteValid(byteValid), .byteData(byteData),
    .frameEnd(frameEnd), .stationAddr(stationAddr), .hashTable(hashTable),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .decisionValid(decisionValid), .accept(accept)
  );

  typedef struct packed {
    logic [47:0] dst;
    logic [3:0]  cfg;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{48'h02_11_22_33_44_55, 4'h0, 1'b1, 4'd4},  // R4 exact station
    '{48'h02_11_22_33_44_54, 4'h0, 1'b0, 4'd4},  // R4 last byte differs
    '{48'h12_11_22_33_44_55, 4'h0, 1'b0, 4'd4},  // R4 first byte differs
    '{48'hFF_FF_FF_FF_FF_FF, 4'h0, 1'b0, 4'd7},  // R7 all-ones, flag off
    '{48'hFF_FF_FF_FF_FF_FF, 4'h1, 1'b1, 4'd7},  // R7 all-ones, flag on
    '{48'hFF_FF_FF_FF_FF_FF, 4'h6, 1'b0, 4'd7},  // R7 group flags ignore all-ones
    '{48'h01_00_5E_00_00_01, 4'h0, 1'b0, 4'd8},  // R8 group, nothing enabled
    '{48'h01_00_5E_00_00_01, 4'h4, 1'b1, 4'd5},  // R5 any-group
    '{48'h01_00_5E_00_00_01, 4'h1, 1'b0, 4'd5},  // R5 all-ones flag alone
    '{48'h01_00_5E_00_00_01, 4'h2, 1'b0, 4'd6},  // R6 hashed, empty table
    '{48'h0A_BB_CC_DD_EE_F0, 4'h8, 1'b1, 4'd3},  // R3 promiscuous, foreign unicast
    '{48'h0A_BB_CC_DD_EE_F0, 4'h0, 1'b0, 4'd8}   // R8 foreign unicast
  };

  task automatic check(input string what, input int req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Independent reference of the R6 index: reflected CRC-32 fed LSB first.
  function automatic logic [5:0] refHashIdx(input logic [47:0] a);
    logic [31:0] c;
    logic [7:0]  b;
    logic        fb;
    c = 32'hFFFF_FFFF;
    for (int n = 0; n < 6; n++) begin
      b = a[47 - 8*n -: 8];
      for (int k = 0; k < 8; k++) begin
        fb = c[0] ^ b[k];
        c  = {1'b0, c[31:1]} ^ ({32{fb}} & 32'hEDB8_8320);
      end
    end
    return c[31:26];
  endfunction

  task automatic writeCfg(input logic [7:0] v);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  // Full frame: six address bytes, then two payload bytes ending the frame.
  task automatic sendFrame(input logic [47:0] dst, input logic expAcc, input int req);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      sof = (i == 0); byteValid = 1'b1; frameEnd = 1'b0; byteData = dst[47 - 8*i -: 8];
    end
    @(negedge clk);
    check("verdict strobe after sixth byte (R9)", 9, decisionValid, 1);
    check("verdict", req, accept, expAcc);
    sof = 1'b0; byteData = 8'hA5;
    @(negedge clk);
    check("strobe one cycle only (R9)", 9, decisionValid, 0);
    frameEnd = 1'b1; byteData = 8'h5A;
    @(negedge clk);
    check("no verdict from payload/end (R9)", 9, decisionValid, 0);
    byteValid = 1'b0; frameEnd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] grp;
    logic [5:0]  hidx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("flags after reset (R1)", 1, cfgRdData, 8'h00);
    check("no verdict after reset (R9)", 9, decisionValid, 0);
    check("accept low after reset (R9)", 9, accept, 0);

    // R1 / R2 flag register
    writeCfg(8'hFF);
    check("write all ones (R1 R2)", 2, cfgRdData, 8'h0F);
    writeCfg(8'hA5);
    check("write A5 (R1)", 1, cfgRdData, 8'h05);
    writeCfg(8'hF0);
    check("reserved-only write (R2)", 2, cfgRdData, 8'h00);
    sendFrame(48'hFF_FF_FF_FF_FF_FF, 1'b0, 2); // R2: upper ones enabled nothing

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      writeCfg({4'h0, VECS[v].cfg});
      sendFrame(VECS[v].dst, VECS[v].exp, int'(VECS[v].req));
    end

    // R6 hashed group, table hit and miss
    grp  = 48'h01_00_5E_7F_00_09;
    hidx = refHashIdx(grp);
    writeCfg(8'h02);
    hashTable = 64'h1 << hidx;
    sendFrame(grp, 1'b1, 6);          // R6 hit
    hashTable = ~(64'h1 << hidx);
    sendFrame(grp, 1'b0, 6);          // R6 miss with all other bits set
    writeCfg(8'h00);
    hashTable = 64'h1 << hidx;
    sendFrame(grp, 1'b0, 6);          // R6 hit but flag off
    hashTable = 64'h0;

    // R10 short frame, even in promiscuous mode
    writeCfg(8'h08);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      sof = (i == 0); byteValid = 1'b1; byteData = 8'h02; frameEnd = (i == 2);
    end
    @(negedge clk);
    check("short frame verdict strobe (R10)", 10, decisionValid, 1);
    check("short frame rejected (R10)", 10, accept, 0);
    sof = 1'b0; byteValid = 1'b0; frameEnd = 1'b0;
    @(negedge clk);
    check("short frame strobe one cycle (R10)", 10, decisionValid, 0);

    // R11 restart: partial address then a new frame
    writeCfg(8'h00);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      sof = (i == 0); byteValid = 1'b1; byteData = 8'hFF; frameEnd = 1'b0;
    end
    @(negedge clk);
    byteValid = 1'b0; sof = 1'b0;
    check("no verdict mid-address (R11)", 11, decisionValid, 0);
    sendFrame(stationAddr, 1'b1, 11); // R11 new start strobe restarts collection

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule